// File: doc/BRIEF.md
# Configurable SPI Frame Master

This block is a single-slave SPI master. It moves one fixed 32-bit word in each direction per transaction, talking to an external power-supply sensing device. It derives its serial clock from the system clock through a 16-bit divider. Clock idle level, the edge used for data, how many leading bits of the returned word are thrown away, and the pause after each frame are all chosen per transaction.

A client presents the configuration and a transmit word, then pulses `start` while `busy` is low. The configuration is copied into the block when `start` is accepted, so later changes on those inputs do not disturb a frame already running. Chip select then frames 34 serial-clock periods: one lead-in period, 32 data periods and one lead-out period. After chip select rises, the block waits one serial-clock period. It then waits a further number of periods of an external coarse timing strobe, if that count is non-zero. At the end of this wait it drops `busy` and pulses `done`. The receive word is meant to be read once `done` has been seen.

Top module: `spi_frame_master`

## Requirements
- R1: Data goes out MSB first on `mosi`, and a slave that samples on its sampling edges collects the full 32-bit transmit word. Before the first serial clock edge of a frame, `mosi` already holds bit 31.
- R2: `cs_n` is low for exactly 34 serial-clock periods, which is 272×(div+1) system cycles. Within that window `sclk` makes exactly 32 active-going edges. `cs_n` is high whenever `busy` is low.
- R3: One serial-clock period is 8×(div+1) system clock cycles, where div is the 16-bit `cfg_div` value.
- R4: `sclk` rests at the latched polarity whenever chip select is high: low for polarity 0, high for polarity 1.
- R5: With phase 0, `miso` is sampled on the first edge of each bit and `mosi` changes on the second edge. With phase 1, `mosi` changes on the first edge and `miso` is sampled on the second.
- R6: With input delay d (0 ≤ d ≤ 32), the first d received bits are discarded. After the frame, `rx_word` equals the previous `rx_word` shifted left by 32−d, with the last 32−d bits from `miso` placed in the low bits in arrival order. When d = 32, `rx_word` is unchanged.
- R7: When the input delay is above 32, `rx_word` keeps its previous value whatever `miso` carries.
- R8: With a gap setting of 0, `busy` is high for exactly 280×(div+1) cycles after `start` is accepted. `done` is high for one cycle, in the first cycle that `busy` is low.
- R9: With a gap setting of n > 0 and a strobe period of P cycles, `busy` lasts 280×(div+1) + k cycles, where (n−1)·P < k ≤ n·P. Strobes are counted only after the one-period wait that follows chip select rising.
- R10: Configuration inputs are latched when `start` is accepted. Changing them during a frame has no effect, and a `start` pulse while `busy` is high is ignored: no further frame follows.
- R11: After reset, `cs_n` is 1, `busy`, `done`, `sclk`, `mosi` are 0 and `rx_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_strobe | input | 1 | One-cycle coarse timing pulse for the inter-frame gap |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on first edge, 1: sample on second edge |
| cfg_in_delay | input | 8 | Number of leading received bits to discard |
| cfg_div | input | 16 | Serial clock divider; period is 8×(div+1) cycles |
| cfg_gap | input | 17 | Extra inter-frame wait counted in strobes |
| start | input | 1 | Begin a transaction when not busy |
| busy | output | 1 | Frame or gap in progress |
| done | output | 1 | One-cycle pulse when the gap ends |
| tx_word | input | 32 | Word to transmit |
| rx_word | output | 32 | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest case to reach is the interaction between the capture delay and the receive word's history. The shift applied to the old value can only be seen if successive frames carry different data and different delays. The bench therefore sweeps polarity, phase and a set of delays covering 0, 1, a middle value, 31, 32, 33 and 255. It feeds distinct slave patterns every time and tracks the expected word frame to frame. A frame is also disturbed mid-flight by flipped configuration and a stray `start`, to show that the latched settings govern it.

// File: rtl/spi_frame_pkg.sv
// Shared types for the SPI frame master.
// Assumes: used only by the spi_frame_master hierarchy.
package spi_frame_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FRAME    = 2'd1,
        ST_GAP_CLK  = 2'd2,
        ST_GAP_STRB = 2'd3
    } fm_state_e;

    // Chip-select periods that carry no data (lead-in plus lead-out).
    localparam int unsigned PAD_SLOTS = 2;
endpackage

// File: rtl/spi_half_tick.sv
// Half-period tick generator: pulses once every 4*(div+1) cycles while run is high.
// Assumes: clear restarts the phase; div is stable while running.
module spi_half_tick #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int unsigned CW = DIV_W + 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // 4*(div+1)-1 equals div followed by two ones
    assign limit = {div, 2'b11};
    assign tick  = run && (cnt == limit);

    // Count system cycles within one half period
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (clear || !run || tick) cnt <= '0;
        else                            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/spi_gap_timer.sv
// Strobe-counted gap timer: loaded at frame start, counts strobes while active.
// Assumes: strobe is a single-cycle pulse in the clk domain.
module spi_gap_timer #(
    parameter int unsigned GAP_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    input  logic             active,
    input  logic             strobe,
    output logic             expire,
    output logic             is_zero
);
    logic [GAP_W-1:0] cnt;

    assign is_zero = (cnt == '0);
    assign expire  = active && strobe && (cnt == GAP_W'(1));

    // Hold the remaining strobe count
    always_ff @(posedge clk) begin
        if (!rst_n)                             cnt <= '0;
        else if (load)                          cnt <= load_val;
        else if (active && strobe && !is_zero)  cnt <= cnt - GAP_W'(1);
    end
endmodule

// File: rtl/spi_shift_core.sv
// Transmit and receive shift registers; receive shifts only for bits at or past the delay.
// Assumes: bit_idx names the data bit being sampled when sample is high.
module spi_shift_core #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DLY_W  = 8,
    parameter int unsigned IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              shift_tx,
    input  logic              sample,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [DLY_W-1:0]  delay,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tx_sh;
    logic              capture_ok;

    localparam int unsigned CMP_W = (DLY_W > IDX_W) ? DLY_W : IDX_W;

    assign capture_ok = (CMP_W'(bit_idx) >= CMP_W'(delay));
    assign mosi       = tx_sh[DATA_W-1];

    // Present transmit bits MSB first
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_sh <= '0;
        else if (load)     tx_sh <= tx_word;
        else if (shift_tx) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
    end

    // Collect received bits into the LSB end
    always_ff @(posedge clk) begin
        if (!rst_n)                    rx_word <= '0;
        else if (sample && capture_ok) rx_word <= {rx_word[DATA_W-2:0], miso};
    end
endmodule

// File: rtl/spi_frame_master.sv
// SPI frame master: one 32-bit exchange per start, then a strobe-timed gap.
// Assumes: single slave; start is honoured only while busy is low;
// every frame is lead-in + DATA_W bits + lead-out serial-clock periods.
module spi_frame_master
    import spi_frame_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DIV_W  = 16,
    parameter int unsigned DLY_W  = 8,
    parameter int unsigned GAP_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_strobe,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DLY_W-1:0]  cfg_in_delay,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              start,
    output logic              busy,
    output logic              done,
    input  logic [DATA_W-1:0] tx_word,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int unsigned HALVES = 2 * (DATA_W + PAD_SLOTS);
    localparam int unsigned HI_W   = $clog2(HALVES + 1);
    localparam int unsigned IDX_W  = $clog2(DATA_W);
    localparam logic [HI_W-1:0] HI_LAST  = HI_W'(HALVES - 1);
    localparam logic [HI_W-1:0] LEAD_LO  = HI_W'(3);
    localparam logic [HI_W-1:0] LEAD_HI  = HI_W'(2 * DATA_W + 1);
    localparam logic [HI_W-1:0] TRAIL_LO = HI_W'(4);
    localparam logic [HI_W-1:0] TRAIL_HI = HI_W'(2 * DATA_W + 2);
    localparam logic [HI_W-1:0] SH0_HI   = HI_W'(2 * DATA_W);
    localparam logic [HI_W-1:0] SH1_LO   = HI_W'(5);

    fm_state_e        state;
    logic [HI_W-1:0]  hi, hn, lead_off, trail_off;
    logic             cpol_q, cpha_q, sclk_q, done_q;
    logic [DLY_W-1:0] dly_q;
    logic [DIV_W-1:0] div_q;
    logic             start_ok, tick, in_frame;
    logic             lead_ev, trail_ev, shift_tx, sample, sclk_act;
    logic [IDX_W-1:0] sample_idx;
    logic             gap_expire, gap_zero;

    assign start_ok  = start && (state == ST_IDLE);
    assign in_frame  = (state == ST_FRAME);
    assign hn        = hi + HI_W'(1);
    assign lead_off  = hn - LEAD_LO;
    assign trail_off = hn - TRAIL_LO;

    // Edge events decoded from the half-period index being entered
    assign lead_ev  = in_frame && tick && hn[0]  && (hn >= LEAD_LO)  && (hn <= LEAD_HI);
    assign trail_ev = in_frame && tick && !hn[0] && (hn >= TRAIL_LO) && (hn <= TRAIL_HI);

    // Phase selects which edge samples and which edge shifts
    always_comb begin
        if (!cpha_q) begin
            sample     = lead_ev;
            sample_idx = lead_off[IDX_W:1];
            shift_tx   = trail_ev && (hn <= SH0_HI);
        end else begin
            sample     = trail_ev;
            sample_idx = trail_off[IDX_W:1];
            shift_tx   = lead_ev && (hn >= SH1_LO);
        end
    end

    // Serial clock is active in the second half of each data period
    assign sclk_act = in_frame && hi[0] && (hi >= LEAD_LO) && (hi <= LEAD_HI);

    spi_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (in_frame || (state == ST_GAP_CLK)),
        .clear (start_ok),
        .div   (start_ok ? cfg_div : div_q),
        .tick  (tick)
    );

    spi_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .load_val (cfg_gap),
        .active   (state == ST_GAP_STRB),
        .strobe   (tick_strobe),
        .expire   (gap_expire),
        .is_zero  (gap_zero)
    );

    spi_shift_core #(.DATA_W(DATA_W), .DLY_W(DLY_W), .IDX_W(IDX_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start_ok),
        .tx_word  (tx_word),
        .shift_tx (shift_tx),
        .sample   (sample),
        .bit_idx  (sample_idx),
        .delay    (dly_q),
        .miso     (miso),
        .mosi     (mosi),
        .rx_word  (rx_word)
    );

    // Latch the configuration on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            dly_q  <= '0;
            div_q  <= '0;
        end else if (start_ok) begin
            cpol_q <= cfg_cpol;
            cpha_q <= cfg_cpha;
            dly_q  <= cfg_in_delay;
            div_q  <= cfg_div;
        end
    end

    // Frame and gap sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            hi     <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (start_ok) begin
                    state <= ST_FRAME;
                    hi    <= '0;
                end
                ST_FRAME: if (tick) begin
                    if (hi == HI_LAST) begin
                        state <= ST_GAP_CLK;
                        hi    <= '0;
                    end else begin
                        hi <= hn;
                    end
                end
                ST_GAP_CLK: if (tick) begin
                    if (hi[0]) begin
                        hi <= '0;
                        if (gap_zero) begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            state <= ST_GAP_STRB;
                        end
                    end else begin
                        hi <= hn;
                    end
                end
                ST_GAP_STRB: if (gap_expire) begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Register the serial clock pin so it cannot glitch
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= cpol_q ^ sclk_act;
    end

    assign sclk = sclk_q;
    assign cs_n = !in_frame;
    assign busy = (state != ST_IDLE);
    assign done = done_q;
endmodule

// File: rtl/spi_frame_master_chk.sv
// Protocol checker for spi_frame_master, attached by bind.
// Assumes: observes port-level signals only.
module spi_frame_master_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              cs_n,
    input logic              sclk,
    input logic [DATA_W-1:0] rx_word
);
    a_r2_cs_high_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    a_r4_sclk_quiet_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> $stable(sclk));

    a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r6_rx_changes_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_word) |-> !cs_n);

    a_r9_gap_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> busy);
endmodule

bind spi_frame_master spi_frame_master_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .rx_word (rx_word)
);

// File: tb/spi_frame_master_bench.sv
`timescale 1ns/1ps
module spi_frame_master_bench;
    localparam int STRB_P = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_strobe = 1'b0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [7:0]  cfg_in_delay = '0;
    logic [15:0] cfg_div = '0;
    logic [16:0] cfg_gap = '0;
    logic        start = 1'b0;
    logic        busy, done, sclk, mosi, cs_n;
    logic        miso = 1'b0;
    logic [31:0] tx_word = '0;
    logic [31:0] rx_word;

    int n_checks = 0;
    int n_fail   = 0;

    // slave model state
    logic [31:0] s_pat = '0;
    logic        s_cpol = 1'b0, s_cpha = 1'b0;
    logic [31:0] s_rx = '0;
    logic [31:0] rx_model = '0;

    always #2.5 clk = ~clk;

    spi_frame_master u_spi_frame_master (
        .clk(clk), .rst_n(rst_n), .tick_strobe(tick_strobe),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_in_delay(cfg_in_delay),
        .cfg_div(cfg_div), .cfg_gap(cfg_gap), .start(start), .busy(busy),
        .done(done), .tx_word(tx_word), .rx_word(rx_word), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // coarse strobe: one pulse every STRB_P cycles
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            c++;
            tick_strobe = (c % STRB_P == 0);
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        report();
    end

    // slave device model
    initial begin
        logic pcs, psclk, seen;
        int sb;
        pcs = 1'b1; psclk = 1'b0; seen = 1'b0; sb = 0;
        forever begin
            @(cs_n or sclk);
            if (cs_n !== pcs) begin
                pcs = cs_n;
                if (!cs_n) begin
                    sb = 0; seen = 1'b0; s_rx = '0;
                    if (!s_cpha) miso = s_pat[31];
                end
            end
            if (sclk !== psclk) begin
                psclk = sclk;
                if (!cs_n) begin
                    if (sclk != s_cpol) begin
                        seen = 1'b1;
                        if (!s_cpha) s_rx = {s_rx[30:0], mosi};
                        else if (sb < 32) miso = s_pat[31-sb];
                    end else if (seen) begin
                        if (!s_cpha) begin
                            sb++;
                            if (sb < 32) miso = s_pat[31-sb];
                        end else begin
                            s_rx = {s_rx[30:0], mosi};
                            sb++;
                        end
                    end
                end
            end
        end
    end

    task automatic run_frame(input logic [31:0] tx, input logic [31:0] pat, input bit cp,
                             input bit ph, input logic [7:0] dly, input logic [15:0] dv,
                             input logic [16:0] gp, input bit poke);
        int bc, cl, leads, t1, t2, k, n, half;
        logic ps;
        logic [63:0] tmp;
        logic [31:0] exp_rx;
        bit mosi_ok, quiet;
        s_pat = pat; s_cpol = cp; s_cpha = ph;
        @(negedge clk);
        cfg_cpol = cp; cfg_cpha = ph; cfg_in_delay = dly; cfg_div = dv; cfg_gap = gp;
        tx_word = tx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mosi_ok = (mosi == tx[31]);
        bc = 0; cl = 0; leads = 0; t1 = -1; t2 = -1; k = 0; ps = sclk;
        while (busy) begin
            bc++;
            if (!cs_n) cl++;
            if (!cs_n && sclk != ps && sclk != cp) begin
                leads++;
                if (t1 < 0) t1 = k; else if (t2 < 0) t2 = k;
            end
            ps = sclk;
            if (poke && k == 40) begin
                cfg_cpol = ~cp; cfg_cpha = ~ph; cfg_in_delay = ~dly; cfg_div = dv + 16'd3;
                cfg_gap = gp + 17'd9; tx_word = ~tx; start = 1'b1;
            end
            if (poke && k == 41) start = 1'b0;
            k++;
            @(negedge clk);
        end
        half = 4 * (int'(dv) + 1);
        check(mosi_ok, "R1 mosi holds MSB before first edge", mosi, tx[31]);
        check(s_rx == tx, $sformatf("R1/R5 slave got tx (cpol=%0d cpha=%0d)", cp, ph), s_rx, tx);
        check(cl == 68 * half, "R2 cs_n low window", cl, 68 * half);
        check(leads == 32, "R2 active sclk edges", leads, 32);
        check(t2 - t1 == 2 * half, "R3 sclk period", t2 - t1, 2 * half);
        check(sclk == cp, "R4 sclk idle level", sclk, cp);
        n = (dly >= 8'd32) ? 0 : 32 - int'(dly);
        tmp = ({32'h0, rx_model} << n) | ({32'h0, pat} & ((64'h1 << n) - 64'h1));
        exp_rx = tmp[31:0];
        if (dly > 8'd32)
            check(rx_word == rx_model, "R7 rx unchanged for large delay", rx_word, rx_model);
        else
            check(rx_word == exp_rx, $sformatf("R6/R5 rx with delay %0d cpha=%0d", dly, ph), rx_word, exp_rx);
        rx_model = exp_rx;
        if (gp == '0)
            check(bc == 70 * half, "R8 busy length gap 0", bc, 70 * half);
        else
            check(bc > 70 * half + (int'(gp) - 1) * STRB_P && bc <= 70 * half + int'(gp) * STRB_P,
                  "R9 busy length with strobe gap", bc, 70 * half + int'(gp) * STRB_P);
        check(done == 1'b1, "R8 done when busy falls", done, 1);
        @(negedge clk);
        check(done == 1'b0, "R8 done lasts one cycle", done, 0);
        if (poke) begin
            quiet = 1'b1;
            repeat (30) begin
                @(negedge clk);
                if (!cs_n || busy) quiet = 1'b0;
            end
            check(quiet, "R10 start during busy ignored", quiet, 1);
        end
    endtask

    initial begin
        logic [31:0] tx, pat;
        logic [7:0] dl [7];
        int idx = 0;
        dl[0] = 8'd0; dl[1] = 8'd1; dl[2] = 8'd7; dl[3] = 8'd31;
        dl[4] = 8'd32; dl[5] = 8'd33; dl[6] = 8'd255;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(cs_n == 1'b1, "R11 cs_n reset", cs_n, 1);
        check(busy == 1'b0, "R11 busy reset", busy, 0);
        check(done == 1'b0, "R11 done reset", done, 0);
        check(sclk == 1'b0, "R11 sclk reset", sclk, 0);
        check(mosi == 1'b0, "R11 mosi reset", mosi, 0);
        check(rx_word == 32'h0, "R11 rx reset", rx_word, 0);
        // sweep polarity, phase and capture delay
        for (int cp = 0; cp < 2; cp++)
            for (int ph = 0; ph < 2; ph++)
                for (int d = 0; d < 7; d++) begin
                    idx++;
                    tx  = 32'hA5C3_0F81 ^ (32'(idx) * 32'h9E37_79B9);
                    pat = {tx[15:0], ~tx[31:16]} ^ 32'(idx * 77);
                    run_frame(tx, pat, cp[0], ph[0], dl[d], 16'd0, 17'd0, 1'b0);
                end
        // other dividers
        for (int dv = 1; dv < 4; dv++)
            for (int ph = 0; ph < 2; ph++)
                run_frame(32'h8000_0001 + 32'(dv), 32'h1357_9BDF ^ 32'(dv), 1'b1, ph[0],
                          8'(dv * 3), 16'(dv), 17'd0, 1'b0);
        // strobe-timed gaps
        for (int g = 1; g < 6; g += 2)
            run_frame(32'hDEAD_BEEF ^ 32'(g), 32'h0F0F_3C3C + 32'(g), 1'b0, 1'b1,
                      8'd4, 16'd0, 17'(g), 1'b0);
        // R10 mid-frame configuration change and stray start
        run_frame(32'h6A09_E667, 32'hBB67_AE85, 1'b0, 1'b0, 8'd2, 16'd1, 17'd2, 1'b1);
        run_frame(32'h3C6E_F372, 32'hA54F_F53A, 1'b1, 1'b1, 8'd10, 16'd0, 17'd0, 1'b1);
        report();
    end
endmodule